// File: doc/BRIEF.md
# Snooping three-state write-back cache coherence controller

This block sits beside one private write-back cache on an atomic shared bus and keeps every line it holds in one of three states: invalid (`LN_I`), shared (`LN_S`) or modified (`LN_M`). The processor side presents one request at a time and holds it until the controller pulses completion, together with a hit flag and the read data. The bus side works in two directions. The controller raises a request carrying a read, a read-for-ownership or a write-back command and waits for a grant. It also watches the transactions that other caches issue and answers them by supplying dirty data and changing the state of its own copy.

Storage is a small direct-mapped array. Each entry holds a tag, a state and one data word that stands for the line. An address is `{tag, index}` at line granularity. The request state machine has four states. `F_IDLE` evaluates the request. `F_WB` writes back a dirty victim. `F_REQ` waits for the grant of the fill or upgrade transaction. `F_DONE` is the single completion cycle. Its transitions are these: idle to done on a local hit, idle to write-back on a dirty victim, idle to request on any other miss or upgrade, write-back to request on grant, request to done on grant, either waiting state back to idle when a snoop touches the same index, and done back to idle.

There is no exclusive state. A read miss therefore always installs a shared copy, and a write to a shared copy always goes out on the bus.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. `cpu_done`, `bus_req` and `snp_flush` are all low.
- R2: A read whose line is invalid or holds another tag issues a bus read (`bus_cmd` = 1) for `cpu_addr`. On grant it installs the line as shared with the `bus_rdata` word and completes with `cpu_hit` = 0 and that word on `cpu_rdata`.
- R3: A write to an invalid line or a shared line issues a read-for-ownership (`bus_cmd` = 2) for `cpu_addr`. On grant it installs the line as modified holding `cpu_wdata` and completes with `cpu_hit` = 0.
- R4: A read of a shared or modified line, or a write to a modified line, completes after exactly one clock with `cpu_hit` = 1 and raises no bus request. `cpu_done` is a one-cycle pulse.
- R5: A snooped bus read (`snp_cmd` = 1) that matches a modified line raises `snp_flush` one cycle later with the line data on `snp_fdata`, and demotes the line to shared.
- R6: A snooped bus read that matches a shared line, and any snoop whose tag does not match, cause no flush and leave the line unchanged.
- R7: A snooped read-for-ownership (`snp_cmd` = 2) that matches a modified line raises `snp_flush` with the line data and invalidates the line.
- R8: A snooped read-for-ownership that matches a shared line invalidates it with no flush.
- R9: A miss that replaces a shared line of another tag discards it silently: the first bus command is the fill itself.
- R10: A miss that replaces a modified line first issues a write-back (`bus_cmd` = 3) with the victim's address `{old tag, index}` and data. The victim becomes invalid, and the fill follows.
- R11: A snoop to the same index as the pending processor request takes effect first. The request is then evaluated against the updated state.
- R12: While `bus_req` is high and not yet granted, `bus_cmd` and `bus_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W | Line address `{tag, index}` |
| cpu_wdata | input | DW | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request completed without a bus transaction |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | TAG_W+IDX_W | Address of the requested transaction |
| bus_wdata | output | DW | Write-back data |
| bus_gnt | input | 1 | Grant; the whole transaction completes in this cycle |
| bus_rdata | input | DW | Fill data, valid with `bus_gnt` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | TAG_W+IDX_W | Snooped address |
| snp_flush | output | 1 | Dirty data supplied for the previous snoop |
| snp_fdata | output | DW | Flushed data |

## Verification
Accesses are walked through every state: the same line goes from invalid to shared to modified and back. This shows whether hits, misses and upgrades each pick the right bus command. Snoops of both kinds are aimed at modified, shared and tag-mismatched lines. A flush appearing or staying absent, together with the hit flag of the following access, shows which state the line was left in. Replacement is tried with a clean and with a dirty victim to tell a silent discard from a write-back. A snoop that coincides with a processor hit to the same index shows whether the snoop wins and turns the hit into a miss. One grant is held back for several cycles to expose any change in the request while it waits.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        LN_I = 2'b00,
        LN_S = 2'b01,
        LN_M = 2'b10
    } line_st_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_RD    = 2'd1,
        OP_RDX   = 2'd2,
        OP_FLUSH = 2'd3
    } bus_op_t;

    typedef enum logic [1:0] {
        F_IDLE,
        F_WB,
        F_REQ,
        F_DONE
    } fsm_t;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    output line_st_t         lk_st,
    output logic [DW-1:0]    lk_data,
    input  logic [IDX_W-1:0] sn_idx,
    output logic [TAG_W-1:0] sn_tag,
    output line_st_t         sn_st,
    output logic [DW-1:0]    sn_data,
    input  logic             sn_we,
    input  line_st_t         sn_st_new,
    input  logic             cw_en,
    input  logic [IDX_W-1:0] cw_idx,
    input  logic [TAG_W-1:0] cw_tag,
    input  line_st_t         cw_st,
    input  logic [DW-1:0]    cw_data
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_arr  [ENTRIES];
    line_st_t         st_arr   [ENTRIES];
    logic [DW-1:0]    data_arr [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [TAG_W-1:0] tag_r;
        line_st_t         st_r;
        logic [DW-1:0]    data_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_r  <= '0;
                st_r   <= LN_I;
                data_r <= '0;
            end else if (sn_we && sn_idx == IDX_W'(e)) begin
                st_r <= sn_st_new;
            end else if (cw_en && cw_idx == IDX_W'(e)) begin
                tag_r  <= cw_tag;
                st_r   <= cw_st;
                data_r <= cw_data;
            end
        end

        assign tag_arr[e]  = tag_r;
        assign st_arr[e]   = st_r;
        assign data_arr[e] = data_r;
    end

    assign lk_tag  = tag_arr[lk_idx];
    assign lk_st   = st_arr[lk_idx];
    assign lk_data = data_arr[lk_idx];
    assign sn_tag  = tag_arr[sn_idx];
    assign sn_st   = st_arr[sn_idx];
    assign sn_data = data_arr[sn_idx];

    // R11: the snoop port and the request port never write one entry together
    p_port_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sn_we && cw_en && sn_idx == cw_idx));
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] sn_tag,
    input  line_st_t         sn_st,
    input  logic [DW-1:0]    sn_data,
    output logic             sn_we,
    output line_st_t         sn_st_new,
    output logic             snp_flush,
    output logic [DW-1:0]    snp_fdata
);
    logic match;
    logic flush_c;

    assign match = snp_valid && (sn_tag == snp_tag) && (sn_st != LN_I);

    always_comb begin
        sn_we     = 1'b0;
        sn_st_new = sn_st;
        flush_c   = 1'b0;
        if (match) begin
            unique case (sn_st)
                LN_M: begin
                    sn_we   = 1'b1;
                    flush_c = 1'b1;
                    sn_st_new = (snp_cmd == OP_RDX) ? LN_I : LN_S;
                end
                LN_S: begin
                    if (snp_cmd == OP_RDX) begin
                        sn_we     = 1'b1;
                        sn_st_new = LN_I;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snp_flush <= 1'b0;
            snp_fdata <= '0;
        end else begin
            snp_flush <= flush_c;
            snp_fdata <= sn_data;
        end
    end

    // R5: a flush only ever answers a snoop seen one cycle before
    p_flush_follows_snoop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> $past(snp_valid));
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4,
    parameter int DW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [TAG_W+IDX_W-1:0] cpu_addr,
    input  logic [DW-1:0]          cpu_wdata,
    output logic                   cpu_done,
    output logic                   cpu_hit,
    output logic [DW-1:0]          cpu_rdata,
    output logic                   bus_req,
    output logic [1:0]             bus_cmd,
    output logic [TAG_W+IDX_W-1:0] bus_addr,
    output logic [DW-1:0]          bus_wdata,
    input  logic                   bus_gnt,
    input  logic [DW-1:0]          bus_rdata,
    input  logic                   snp_valid,
    input  logic [IDX_W-1:0]       snp_idx,
    output logic [IDX_W-1:0]       lk_idx,
    input  logic [TAG_W-1:0]       lk_tag,
    input  line_st_t               lk_st,
    input  logic [DW-1:0]          lk_data,
    output logic                   cw_en,
    output logic [IDX_W-1:0]       cw_idx,
    output logic [TAG_W-1:0]       cw_tag,
    output line_st_t               cw_st,
    output logic [DW-1:0]          cw_data
);
    localparam int AW = TAG_W + IDX_W;

    fsm_t          state, nxt;
    logic          hit_q;
    logic [DW-1:0] rdata_q;
    logic          set_res, res_hit;
    logic [DW-1:0] res_data;
    bus_op_t       cmd_c;

    logic [IDX_W-1:0] cpu_idx;
    logic [TAG_W-1:0] cpu_tag;
    logic snp_same, tag_eq, rd_hit, wr_hit, dirty_victim;

    assign cpu_idx      = cpu_addr[IDX_W-1:0];
    assign cpu_tag      = cpu_addr[AW-1:IDX_W];
    assign lk_idx       = cpu_idx;
    assign snp_same     = snp_valid && (snp_idx == cpu_idx);
    assign tag_eq       = (lk_tag == cpu_tag);
    assign rd_hit       = !cpu_we && tag_eq && (lk_st != LN_I);
    assign wr_hit       = cpu_we && tag_eq && (lk_st == LN_M);
    assign dirty_victim = !tag_eq && (lk_st == LN_M);

    always_comb begin
        nxt      = state;
        cw_en    = 1'b0;
        cw_idx   = cpu_idx;
        cw_tag   = cpu_tag;
        cw_st    = LN_I;
        cw_data  = cpu_wdata;
        set_res  = 1'b0;
        res_hit  = 1'b0;
        res_data = lk_data;
        unique case (state)
            F_IDLE: begin
                if (cpu_req && !snp_same) begin
                    if (rd_hit) begin
                        nxt      = F_DONE;
                        set_res  = 1'b1;
                        res_hit  = 1'b1;
                        res_data = lk_data;
                    end else if (wr_hit) begin
                        nxt      = F_DONE;
                        set_res  = 1'b1;
                        res_hit  = 1'b1;
                        res_data = cpu_wdata;
                        cw_en    = 1'b1;
                        cw_st    = LN_M;
                    end else if (dirty_victim) begin
                        nxt = F_WB;
                    end else begin
                        nxt = F_REQ;
                    end
                end
            end
            F_WB: begin
                if (snp_same) begin
                    nxt = F_IDLE;
                end else if (bus_gnt) begin
                    cw_en   = 1'b1;
                    cw_tag  = lk_tag;
                    cw_st   = LN_I;
                    cw_data = lk_data;
                    nxt     = F_REQ;
                end
            end
            F_REQ: begin
                if (snp_same) begin
                    nxt = F_IDLE;
                end else if (bus_gnt) begin
                    cw_en    = 1'b1;
                    cw_st    = cpu_we ? LN_M : LN_S;
                    cw_data  = cpu_we ? cpu_wdata : bus_rdata;
                    set_res  = 1'b1;
                    res_hit  = 1'b0;
                    res_data = cpu_we ? cpu_wdata : bus_rdata;
                    nxt      = F_DONE;
                end
            end
            F_DONE: nxt = F_IDLE;
            default: nxt = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= F_IDLE;
            hit_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            if (set_res) begin
                hit_q   <= res_hit;
                rdata_q <= res_data;
            end
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        cmd_c     = OP_NONE;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        unique case (state)
            F_WB: begin
                bus_req   = 1'b1;
                cmd_c     = OP_FLUSH;
                bus_addr  = {lk_tag, cpu_idx};
                bus_wdata = lk_data;
            end
            F_REQ: begin
                bus_req = 1'b1;
                cmd_c   = cpu_we ? OP_RDX : OP_RD;
            end
            default: ;
        endcase
    end

    assign bus_cmd   = cmd_c;
    assign cpu_done  = (state == F_DONE);
    assign cpu_hit   = hit_q;
    assign cpu_rdata = rdata_q;

    // R12: a waiting request keeps its command and address
    p_cmd_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt && !snp_same |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

    // R4: completion lasts one cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R4: a hit completes with no bus request in the cycle before
    p_hit_no_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && cpu_hit |-> $past(!bus_req));

    // R2: a miss completion always follows a grant
    p_miss_after_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && !cpu_hit |-> $past(bus_gnt));
endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4,
    parameter int DW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [TAG_W+IDX_W-1:0] cpu_addr,
    input  logic [DW-1:0]          cpu_wdata,
    output logic                   cpu_done,
    output logic                   cpu_hit,
    output logic [DW-1:0]          cpu_rdata,
    output logic                   bus_req,
    output logic [1:0]             bus_cmd,
    output logic [TAG_W+IDX_W-1:0] bus_addr,
    output logic [DW-1:0]          bus_wdata,
    input  logic                   bus_gnt,
    input  logic [DW-1:0]          bus_rdata,
    input  logic                   snp_valid,
    input  logic [1:0]             snp_cmd,
    input  logic [TAG_W+IDX_W-1:0] snp_addr,
    output logic                   snp_flush,
    output logic [DW-1:0]          snp_fdata
);
    localparam int AW = TAG_W + IDX_W;

    logic [IDX_W-1:0] lk_idx, cw_idx, snp_idx;
    logic [TAG_W-1:0] lk_tag, sn_tag, cw_tag, snp_tag;
    line_st_t         lk_st, sn_st, sn_st_new, cw_st;
    logic [DW-1:0]    lk_data, sn_data, cw_data;
    logic             sn_we, cw_en;

    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[AW-1:IDX_W];

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_st(lk_st), .lk_data(lk_data),
        .sn_idx(snp_idx), .sn_tag(sn_tag), .sn_st(sn_st), .sn_data(sn_data),
        .sn_we(sn_we), .sn_st_new(sn_st_new),
        .cw_en(cw_en), .cw_idx(cw_idx), .cw_tag(cw_tag), .cw_st(cw_st), .cw_data(cw_data)
    );

    msi_snoop_unit #(.TAG_W(TAG_W), .DW(DW)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_tag),
        .sn_tag(sn_tag), .sn_st(sn_st), .sn_data(sn_data),
        .sn_we(sn_we), .sn_st_new(sn_st_new),
        .snp_flush(snp_flush), .snp_fdata(snp_fdata)
    );

    msi_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_idx(snp_idx),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_st(lk_st), .lk_data(lk_data),
        .cw_en(cw_en), .cw_idx(cw_idx), .cw_tag(cw_tag), .cw_st(cw_st), .cw_data(cw_data)
    );
endmodule

// File: tb/sim_msi_snoop_cache.sv
module sim_msi_snoop_cache;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_done, cpu_hit;
    logic [7:0] cpu_rdata;
    logic       bus_req;
    logic [1:0] bus_cmd;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_gnt = 1'b0;
    logic [7:0] bus_rdata = '0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [5:0] snp_addr = '0;
    logic       snp_flush;
    logic [7:0] snp_fdata;

    int n_chk = 0, n_fail = 0, breq_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    msi_snoop_cache u0 (.*);

    always @(posedge clk) if (bus_req) breq_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic start_req(input bit we, input logic [5:0] a, input logic [7:0] d);
        cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
    endtask

    task automatic expect_bus(input logic [1:0] cmd, input logic [5:0] a, input bit chk_d,
                              input logic [7:0] d, input logic [7:0] fill, input int dly,
                              input string req);
        for (int w = 0; w < 20 && !bus_req; w++) @(negedge clk);
        chk(bus_req == 1'b1, req, bus_req, 1);
        chk(bus_cmd == cmd, req, bus_cmd, cmd);
        chk(bus_addr == a, req, bus_addr, a);
        if (chk_d) chk(bus_wdata == d, req, bus_wdata, d);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk(bus_req && bus_cmd == cmd && bus_addr == a, "R12", {bus_cmd, bus_addr}, {cmd, a});
        end
        bus_gnt = 1'b1; bus_rdata = fill;
        @(negedge clk);
        bus_gnt = 1'b0;
    endtask

    task automatic expect_done(input bit hit, input logic [7:0] d, input string req);
        for (int w = 0; w < 20 && !cpu_done; w++) @(negedge clk);
        chk(cpu_done == 1'b1, req, cpu_done, 1);
        chk(cpu_hit == hit, req, cpu_hit, hit);
        chk(cpu_rdata == d, req, cpu_rdata, d);
        cpu_req = 1'b0;
        @(negedge clk);
        chk(cpu_done == 1'b0, "R4", cpu_done, 0);
    endtask

    task automatic hit_access(input bit we, input logic [5:0] a, input logic [7:0] d,
                              input logic [7:0] exp_d, input string req);
        int n0 = breq_cnt;
        start_req(we, a, d);
        expect_done(1'b1, exp_d, req);
        chk(breq_cnt == n0, req, breq_cnt - n0, 0);
    endtask

    task automatic miss_access(input bit we, input logic [5:0] a, input logic [7:0] d,
                               input logic [1:0] cmd, input logic [7:0] fill,
                               input logic [7:0] exp_d, input string req);
        start_req(we, a, d);
        expect_bus(cmd, a, 1'b0, 8'h0, fill, 0, req);
        expect_done(1'b0, exp_d, req);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [5:0] a, input bit exp_f,
                         input logic [7:0] exp_d, input string req);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        chk(snp_flush == exp_f, req, snp_flush, exp_f);
        if (exp_f) chk(snp_fdata == exp_d, req, snp_fdata, exp_d);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_done && !bus_req && !snp_flush, "R1", {cpu_done, bus_req, snp_flush}, 0);
    endtask

    task automatic t_read_write_path();
        // R1 R2: first read misses, delayed grant exercises R12
        start_req(1'b0, 6'h05, 8'h0);
        expect_bus(2'd1, 6'h05, 1'b0, 8'h0, 8'hA5, 3, "R2");
        expect_done(1'b0, 8'hA5, "R2");
        hit_access(1'b0, 6'h05, 8'h0, 8'hA5, "R4");
        // R3: write to shared line upgrades through the bus
        miss_access(1'b1, 6'h05, 8'h3C, 2'd2, 8'hEE, 8'h3C, "R3");
        hit_access(1'b1, 6'h05, 8'h3D, 8'h3D, "R4");
        hit_access(1'b0, 6'h05, 8'h0, 8'h3D, "R4");
    endtask

    task automatic t_snoop_cases();
        snoop(2'd1, 6'h05, 1'b1, 8'h3D, "R5");
        hit_access(1'b0, 6'h05, 8'h0, 8'h3D, "R5");
        snoop(2'd1, 6'h05, 1'b0, 8'h0, "R6");
        hit_access(1'b0, 6'h05, 8'h0, 8'h3D, "R6");
        snoop(2'd2, 6'h05, 1'b0, 8'h0, "R8");
        miss_access(1'b0, 6'h05, 8'h0, 2'd1, 8'h11, 8'h11, "R8");
        // R3 from invalid, then R7
        miss_access(1'b1, 6'h0A, 8'h77, 2'd2, 8'hEE, 8'h77, "R3");
        snoop(2'd2, 6'h0A, 1'b1, 8'h77, "R7");
        miss_access(1'b0, 6'h0A, 8'h0, 2'd1, 8'h22, 8'h22, "R7");
        // R6: tag mismatch on same index leaves the line alone
        snoop(2'd2, 6'h1A, 1'b0, 8'h0, "R6");
        hit_access(1'b0, 6'h0A, 8'h0, 8'h22, "R6");
    endtask

    task automatic t_replace();
        // R9: shared victim at index 1 dropped silently
        miss_access(1'b0, 6'h15, 8'h0, 2'd1, 8'h44, 8'h44, "R9");
        // R10: dirty victim at index 3 written back first
        miss_access(1'b1, 6'h0B, 8'h55, 2'd2, 8'hEE, 8'h55, "R10");
        hit_access(1'b1, 6'h0B, 8'h56, 8'h56, "R10");
        start_req(1'b0, 6'h1F, 8'h0);
        expect_bus(2'd3, 6'h0B, 1'b1, 8'h56, 8'h00, 0, "R10");
        expect_bus(2'd1, 6'h1F, 1'b0, 8'h0, 8'h99, 0, "R10");
        expect_done(1'b0, 8'h99, "R10");
        snoop(2'd2, 6'h0B, 1'b0, 8'h0, "R10");
    endtask

    task automatic t_priority();
        miss_access(1'b1, 6'h00, 8'h61, 2'd2, 8'hEE, 8'h61, "R11");
        // snoop and a would-be hit to the same index in one cycle
        start_req(1'b0, 6'h00, 8'h0);
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 6'h00;
        @(negedge clk);
        snp_valid = 1'b0;
        chk(snp_flush == 1'b1, "R11", snp_flush, 1);
        chk(snp_fdata == 8'h61, "R11", snp_fdata, 8'h61);
        expect_bus(2'd1, 6'h00, 1'b0, 8'h0, 8'h70, 0, "R11");
        expect_done(1'b0, 8'h70, "R11");
    endtask

    initial begin
        t_reset();
        t_read_write_path();
        t_snoop_cases();
        t_replace();
        t_priority();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end
endmodule